// File: doc/BRIEF.md
# Mode-Configurable Distributed RAM Cell

This block holds 32 one-bit storage cells and presents them in one of four organisations chosen by a static 2-bit mode input. It can act as a 16-deep single-port RAM, as two independent 16-deep single-port RAMs, as one 32-deep single-port RAM, or as a 16-deep dual-port RAM. In the dual-port case, port A writes and reads and port B only reads.

Writes take effect on the rising edge of the clock, and only when the write enable is high at that edge. The address, data and enable are sampled at the edge, so later changes on those inputs cannot disturb the stored value. Reads are combinational: each output follows its address without waiting for a clock.

The mode is meant to be tied off for a given use. Changing it outside reset is not supported. A synchronous reset clears all cells.

Cell mapping:
- Port A in the 16-deep modes (0, 1 and 3) uses cells 0..15.
- Port B in mode 1 uses cells 16..31.
- Mode 2 addresses all 32 cells directly.

Top module: `dram_cell`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, all 32 cells are cleared. After reset, both read outputs are 0 at every address.
- R2: Mode 0 (16x1 single port): `a_addr_i[3:0]` selects one of cells 0..15 for both read and write. `a_addr_i[4]`, `b_addr_i` and `b_din_i` have no effect.
- R3: Mode 1 (two 16x1 single ports): port A uses `a_addr_i[3:0]`, `a_din_i` and `a_dout_o` on cells 0..15. Port B uses `b_addr_i`, `b_din_i` and `b_dout_o` on cells 16..31. One `we_i` writes both ports at the same edge, and each port reads independently.
- R4: Mode 2 (32x1 single port): the full 5-bit `a_addr_i` selects one of 32 cells for read and write.
- R5: Mode 3 (16x1 dual port): port A writes and reads cells 0..15 at `a_addr_i[3:0]`. `b_dout_o` reads cell `b_addr_i` from the same 16 cells. `b_din_i` and `a_addr_i[4]` have no effect.
- R6: When `we_i` is low at a rising edge, no cell changes.
- R7: In mode 3, when port B reads the address that port A is writing, `b_dout_o` shows the old value before the edge and the new value after it.
- R8: In modes 0 and 2, `b_dout_o` is held at 0.
- R9: Reads are combinational. Right after a write edge, the output addressing the written cell shows the new value with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous clear of all cells |
| mode_i | input | 2 | Organisation: 0 = 16x1, 1 = two 16x1, 2 = 32x1, 3 = dual-port 16x1 |
| we_i | input | 1 | Write enable sampled at the rising edge |
| a_addr_i | input | 5 | Port A address; bit 4 is used in mode 2 only |
| a_din_i | input | 1 | Port A write data |
| a_dout_o | output | 1 | Port A read data |
| b_addr_i | input | 4 | Port B address (modes 1 and 3) |
| b_din_i | input | 1 | Port B write data (mode 1 only) |
| b_dout_o | output | 1 | Port B read data; 0 in modes 0 and 2 |

## Verification
The bench builds the block with its default half-array address width of 4, which gives 32 cells in total. With 32 cells, random addresses revisit each location many times in every mode, so overwrites and read-after-write cases come up often.

Because the mode is a port and not a parameter, a single build reaches all four organisations. The bench clears the array between modes.

This width also makes port-A/port-B address collisions in dual-port mode frequent under random stimulus. The same-address case is additionally forced by directed vectors.

// File: rtl/dram_pkg.sv
package dram_pkg;
    typedef enum logic [1:0] {
        MODE_SP16   = 2'd0,
        MODE_SP16X2 = 2'd1,
        MODE_SP32   = 2'd2,
        MODE_DP16   = 2'd3
    } dram_mode_e;
endpackage

// File: rtl/dram_wr_decode.sv
// Turns mode, addresses and data into one write strobe and one data bit per cell.
module dram_wr_decode
    import dram_pkg::*;
#(
    parameter int HALF_AW = 4,
    localparam int FULL_AW = HALF_AW + 1,
    localparam int DEPTH   = 1 << FULL_AW
) (
    input  dram_mode_e           mode,
    input  logic                 we,
    input  logic [FULL_AW-1:0]   a_addr,
    input  logic                 a_din,
    input  logic [HALF_AW-1:0]   b_addr,
    input  logic                 b_din,
    output logic [DEPTH-1:0]     wen,
    output logic [DEPTH-1:0]     wdat
);
    logic [FULL_AW-1:0] lo_idx;
    logic [FULL_AW-1:0] hi_idx;

    assign lo_idx = {1'b0, a_addr[HALF_AW-1:0]};
    assign hi_idx = {1'b1, b_addr};

    always_comb begin
        wen  = '0;
        wdat = '0;
        if (we) begin
            unique case (mode)
                MODE_SP16, MODE_DP16: begin
                    wen[lo_idx]  = 1'b1;
                    wdat[lo_idx] = a_din;
                end
                MODE_SP16X2: begin
                    wen[lo_idx]  = 1'b1;
                    wdat[lo_idx] = a_din;
                    wen[hi_idx]  = 1'b1;
                    wdat[hi_idx] = b_din;
                end
                MODE_SP32: begin
                    wen[a_addr]  = 1'b1;
                    wdat[a_addr] = a_din;
                end
            endcase
        end
    end
endmodule

// File: rtl/dram_cell_array.sv
// One flop per cell, loaded at the edge from the sampled strobe and data.
module dram_cell_array #(
    parameter int HALF_AW = 4,
    localparam int DEPTH  = 1 << (HALF_AW + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DEPTH-1:0] wen,
    input  logic [DEPTH-1:0] wdat,
    output logic [DEPTH-1:0] cells
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic bit_q;
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                bit_q <= 1'b0;
            end else if (wen[i]) begin
                bit_q <= wdat[i];
            end
        end
        assign cells[i] = bit_q;
    end
endmodule

// File: rtl/dram_rd_mux.sv
// Combinational read selection for both ports.
module dram_rd_mux
    import dram_pkg::*;
#(
    parameter int HALF_AW = 4,
    localparam int FULL_AW = HALF_AW + 1,
    localparam int DEPTH   = 1 << FULL_AW
) (
    input  dram_mode_e         mode,
    input  logic [DEPTH-1:0]   cells,
    input  logic [FULL_AW-1:0] a_addr,
    input  logic [HALF_AW-1:0] b_addr,
    output logic               a_dout,
    output logic               b_dout
);
    always_comb begin
        a_dout = cells[{1'b0, a_addr[HALF_AW-1:0]}];
        b_dout = 1'b0;
        unique case (mode)
            MODE_SP16:   ;
            MODE_SP16X2: b_dout = cells[{1'b1, b_addr}];
            MODE_SP32:   a_dout = cells[a_addr];
            MODE_DP16:   b_dout = cells[{1'b0, b_addr}];
        endcase
    end
endmodule

// File: rtl/dram_cell.sv
module dram_cell
    import dram_pkg::*;
#(
    parameter int HALF_AW = 4,
    localparam int FULL_AW = HALF_AW + 1,
    localparam int DEPTH   = 1 << FULL_AW
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [1:0]         mode_i,
    input  logic               we_i,
    input  logic [FULL_AW-1:0] a_addr_i,
    input  logic               a_din_i,
    output logic               a_dout_o,
    input  logic [HALF_AW-1:0] b_addr_i,
    input  logic               b_din_i,
    output logic               b_dout_o
);
    dram_mode_e       mode;
    logic [DEPTH-1:0] wen;
    logic [DEPTH-1:0] wdat;
    logic [DEPTH-1:0] cells;

    assign mode = dram_mode_e'(mode_i);

    dram_wr_decode #(.HALF_AW(HALF_AW)) i_dec (
        .mode   (mode),
        .we     (we_i),
        .a_addr (a_addr_i),
        .a_din  (a_din_i),
        .b_addr (b_addr_i),
        .b_din  (b_din_i),
        .wen    (wen),
        .wdat   (wdat)
    );

    dram_cell_array #(.HALF_AW(HALF_AW)) i_arr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wen    (wen),
        .wdat   (wdat),
        .cells  (cells)
    );

    dram_rd_mux #(.HALF_AW(HALF_AW)) i_rd (
        .mode   (mode),
        .cells  (cells),
        .a_addr (a_addr_i),
        .b_addr (b_addr_i),
        .a_dout (a_dout_o),
        .b_dout (b_dout_o)
    );
endmodule

// File: rtl/dram_cell_chk.sv
module dram_cell_chk #(
    parameter int HALF_AW = 4,
    localparam int FULL_AW = HALF_AW + 1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [1:0]         mode_i,
    input logic               we_i,
    input logic [FULL_AW-1:0] a_addr_i,
    input logic               a_din_i,
    input logic               a_dout_o,
    input logic [HALF_AW-1:0] b_addr_i,
    input logic               b_dout_o
);
    AST_SP32_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && mode_i == 2'd2) ##1 (a_addr_i == $past(a_addr_i) && $stable(mode_i))
        |-> (a_dout_o == $past(a_din_i))); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!we_i) ##1 (a_addr_i == $past(a_addr_i) && $stable(mode_i))
        |-> (a_dout_o == $past(a_dout_o))); // R6

    AST_UNUSED_B_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd0 || mode_i == 2'd2) |-> (b_dout_o == 1'b0)); // R8

    AST_DP_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && mode_i == 2'd3 && a_addr_i[HALF_AW-1:0] == b_addr_i)
        ##1 (b_addr_i == $past(b_addr_i) && $stable(mode_i))
        |-> (b_dout_o == $past(a_din_i))); // R7
endmodule

bind dram_cell dram_cell_chk #(.HALF_AW(HALF_AW)) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .we_i     (we_i),
    .a_addr_i (a_addr_i),
    .a_din_i  (a_din_i),
    .a_dout_o (a_dout_o),
    .b_addr_i (b_addr_i),
    .b_dout_o (b_dout_o)
);

// File: tb/test_dram_cell.sv
`timescale 1ns/1ps
module test_dram_cell;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       we = 1'b0;
    logic [4:0] a_addr = '0;
    logic       a_din = 1'b0;
    logic [3:0] b_addr = '0;
    logic       b_din = 1'b0;
    logic       a_dout;
    logic       b_dout;

    logic [31:0] mdl = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dram_cell i_dram_cell (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .mode_i   (mode),
        .we_i     (we),
        .a_addr_i (a_addr),
        .a_din_i  (a_din),
        .a_dout_o (a_dout),
        .b_addr_i (b_addr),
        .b_din_i  (b_din),
        .b_dout_o (b_dout)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (mode %0d a %0d b %0d)",
                     req, act, exp, mode, a_addr, b_addr);
        end
    endtask

    function automatic logic exp_a(logic [1:0] m, logic [4:0] a);
        return (m == 2'd2) ? mdl[a] : mdl[{1'b0, a[3:0]}];
    endfunction

    function automatic logic exp_b(logic [1:0] m, logic [3:0] b);
        if (m == 2'd1) return mdl[{1'b1, b}];
        if (m == 2'd3) return mdl[{1'b0, b}];
        return 1'b0;
    endfunction

    task automatic mdl_write(logic [1:0] m, logic [4:0] a, logic ad, logic [3:0] b, logic bd);
        if (m == 2'd2) mdl[a] = ad;
        else mdl[{1'b0, a[3:0]}] = ad;
        if (m == 2'd1) mdl[{1'b1, b}] = bd;
    endtask

    task automatic apply(logic w, logic [4:0] a, logic ad, logic [3:0] b, logic bd, string req);
        string req_b;
        @(negedge clk);
        we = w; a_addr = a; a_din = ad; b_addr = b; b_din = bd;
        #1;
        req_b = (mode == 2'd0 || mode == 2'd2) ? "R8" : req;
        chk(req, a_dout, exp_a(mode, a));
        chk(req_b, b_dout, exp_b(mode, b));
        @(posedge clk);
        if (w) mdl_write(mode, a, ad, b, bd);
    endtask

    task automatic do_reset(logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; we = 1'b1; a_din = 1'b1; b_din = 1'b1; mode = m;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; we = 1'b0;
        mdl = '0;
        for (int k = 0; k < 4; k++) begin
            a_addr = 5'(k * 9 + 3); b_addr = 4'(k * 5 + 1);
            #1;
            chk("R1", a_dout, 1'b0);
            chk("R1", b_dout, 1'b0);
        end
    endtask

    task automatic run_mode(logic [1:0] m, string req);
        do_reset(m);
        // write then read back with the same address: combinational read (R9)
        apply(1'b1, 5'h15, 1'b1, 4'h5, 1'b1, req);
        apply(1'b0, 5'h15, 1'b0, 4'h5, 1'b0, "R9");
        // enable low must leave the cell unchanged (R6)
        apply(1'b0, 5'h15, 1'b0, 4'h5, 1'b0, "R6");
        // upper address bit toggled against the same low bits (R2/R4 split)
        apply(1'b0, 5'h05, 1'b0, 4'h6, 1'b0, req);
        if (m == 2'd3) begin
            // same-address collision: old before edge, new after (R7)
            apply(1'b1, 5'h07, 1'b1, 4'h7, 1'b0, "R7");
            apply(1'b1, 5'h07, 1'b0, 4'h7, 1'b1, "R7");
            apply(1'b0, 5'h07, 1'b1, 4'h7, 1'b1, "R7");
        end
        for (int k = 0; k < 400; k++) begin
            logic [4:0] ra;
            logic [3:0] rb;
            ra = 5'($urandom);
            rb = (m == 2'd3 && ($urandom_range(0, 3) == 0)) ? ra[3:0] : 4'($urandom);
            apply(1'($urandom), ra, 1'($urandom), rb, 1'($urandom), req);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        run_mode(2'd0, "R2");
        run_mode(2'd1, "R3");
        run_mode(2'd2, "R4");
        run_mode(2'd3, "R5");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule